// File: doc/BRIEF.md
# Dual-Mode Hardware Breakpoint Comparator

This block watches a CPU's address and data buses and raises a one-cycle request for background debug entry when a programmed match occurs. It has two compare registers, each `W` bits wide. The primary register always holds an address. The secondary register holds either a data value or a second address. A control register selects the mode and qualifies each comparison. Software loads all three registers through a small decoded write port that has separate high-byte and low-byte strobes.

In combined mode the primary register is compared with the address bus and the secondary register with the data bus. A request needs every enabled comparison to match. In dual mode the secondary register is also compared with the address bus. This gives two independent address-only breakpoints, and either one can fire. A request needs the debug-enabled input to be high and the debug-active input to be low. The debug monitor, the serial interface and CPU halting all live outside this block.

Top module: `bkpt_unit`

## Requirements
- R1: After reset all three registers hold zero, both breakpoints are disabled, and `bkpt_req_o` stays low for any bus traffic.
- R2: A write at `wr_addr_i` 0 loads control, 1 loads the primary (address) register and 2 loads the secondary register. A write at 3 changes nothing. `wr_hi_i` updates bits W-1:8 only and `wr_lo_i` updates bits 7:0 only. The control bits are: 0 primary enable, 1 secondary enable, 2 dual mode, 3 program-only, 4 primary low-byte ignore, 5 8-bit data size, 6 secondary low-byte ignore, 7 primary direction-qualify enable, 8 primary direction select, 9 secondary direction-qualify enable, 10 secondary direction select.
- R3: In combined mode, a request needs at least one enable set. The primary register must equal the address if its enable is set, and the secondary register must equal the data if its enable is set.
- R4: In dual mode the secondary register is compared with the address bus and is gated by the secondary enable bit. A match of either enabled breakpoint fires.
- R5: In combined mode the 8-bit size bit limits the data compare to bits 7:0. In dual mode that bit has no effect.
- R6: Each low-byte-ignore bit excludes bits 7:0 from its own register's comparison.
- R7: When the program-only bit is set, only bus cycles with `bus_fetch_i` high can fire.
- R8: When a direction-qualify enable is set, that register's match also needs `bus_rd_i` to equal its select bit, where 1 means read. This applies in both modes.
- R9: No request is raised while `dbg_active_i` is high.
- R10: No request is raised while `dbg_en_i` is low.
- R11: `bkpt_req_o` rises in the cycle after a qualifying bus cycle sampled with `bus_valid_i` high, and it lasts one cycle per such bus cycle. A matching bus value with `bus_valid_i` low fires nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_hi_i | input | 1 | High-byte write enable |
| wr_lo_i | input | 1 | Low-byte write enable |
| wr_data_i | input | W | Write data |
| bus_valid_i | input | 1 | Bus cycle valid |
| bus_addr_i | input | W | CPU address bus |
| bus_data_i | input | W | CPU data bus |
| bus_rd_i | input | 1 | Bus direction, 1 = read |
| bus_fetch_i | input | 1 | Instruction-fetch cycle |
| dbg_en_i | input | 1 | Debug mode enabled |
| dbg_active_i | input | 1 | Debug mode currently active |
| bkpt_req_o | output | 1 | Breakpoint request pulse |

## Verification
The bench runs several bus patterns in each mode.
- Address and data values differing in one bit separate the AND of combined mode from the OR of dual mode.
- The same value placed on the data bus and then on the address bus shows which bus the secondary register watches in each mode.
- Values that differ only in the high byte or only in the low byte separate the low-byte-ignore masking from the 8-bit size masking, and show that the size bit is dropped in dual mode.
- Reads against writes and fetches against data cycles confirm the direction and program-only qualifiers.
- Back-to-back valid cycles and an idle matching cycle pin down the pulse timing.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned CTRL_W = 11;

  typedef struct packed {
    logic rw1;          // 10
    logic rwe1;         // 9
    logic rw0;          // 8
    logic rwe0;         // 7
    logic data_ign_lo;  // 6
    logic size8;        // 5
    logic addr_ign_lo;  // 4
    logic prog_only;    // 3
    logic dual;         // 2
    logic en_d;         // 1
    logic en_a;         // 0
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned LO_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic         wr_hi_i,
  input  logic         wr_lo_i,
  input  logic [W-1:0] wr_data_i,
  output ctrl_t        ctrl_o,
  output logic [W-1:0] addr_ref_o,
  output logic [W-1:0] data_ref_o
);
  localparam int unsigned HI_W = W - LO_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      addr_q, data_q;
  logic              sel_ctrl, sel_addr, sel_data;

  assign sel_ctrl = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_CTRL);
  assign sel_addr = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_ADDR);
  assign sel_data = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (sel_ctrl && wr_lo_i) ctrl_q[LO_W-1:0]      <= wr_data_i[LO_W-1:0];
      if (sel_ctrl && wr_hi_i) ctrl_q[CTRL_W-1:LO_W] <= wr_data_i[CTRL_W-1:LO_W];
      if (sel_addr && wr_lo_i) addr_q[LO_W-1:0]      <= wr_data_i[LO_W-1:0];
      if (sel_addr && wr_hi_i) addr_q[W-1:LO_W]      <= wr_data_i[W-1:LO_W];
      if (sel_data && wr_lo_i) data_q[LO_W-1:0]      <= wr_data_i[LO_W-1:0];
      if (sel_data && wr_hi_i) data_q[W-1:LO_W]      <= wr_data_i[W-1:LO_W];
    end
  end

  assign ctrl_o     = ctrl_t'(ctrl_q);
  assign addr_ref_o = addr_q;
  assign data_ref_o = data_q;

  if (HI_W == 0) begin : g_bad_width
    initial $error("bkpt_regs: W must exceed LO_W");
  end
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
  parameter int unsigned W    = 16,
  parameter int unsigned LO_W = 8
) (
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] opnd_i,
  input  logic         ign_lo_i,
  input  logic         only_lo_i,
  input  logic         rwe_i,
  input  logic         rw_i,
  input  logic         bus_rd_i,
  output logic         hit_o
);
  logic [W-1:0] mask;
  logic         val_eq, dir_ok;

  always_comb begin
    mask = '1;
    if (ign_lo_i)  mask[LO_W-1:0] = '0;
    if (only_lo_i) mask[W-1:LO_W] = '0;
  end

  assign val_eq = ((ref_i ^ opnd_i) & mask) == '0;
  assign dir_ok = !rwe_i || (rw_i == bus_rd_i);
  assign hit_o  = val_eq && dir_ok;
endmodule

// File: rtl/bkpt_req.sv
module bkpt_req (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] hit_i,
  input  logic [1:0] en_i,
  input  logic       dual_i,
  input  logic       prog_only_i,
  input  logic       bus_valid_i,
  input  logic       bus_fetch_i,
  input  logic       dbg_en_i,
  input  logic       dbg_active_i,
  output logic       req_o
);
  logic match_and, match_or, match, gate, req_q;

  // combined: every enabled compare must hit; dual: any enabled compare
  assign match_and = (|en_i) && (!en_i[0] || hit_i[0]) && (!en_i[1] || hit_i[1]);
  assign match_or  = |(en_i & hit_i);
  assign match     = dual_i ? match_or : match_and;
  assign gate      = bus_valid_i && dbg_en_i && !dbg_active_i &&
                     (!prog_only_i || bus_fetch_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= match && gate;
  end

  assign req_o = req_q;
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned LO_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic         wr_hi_i,
  input  logic         wr_lo_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         bus_valid_i,
  input  logic [W-1:0] bus_addr_i,
  input  logic [W-1:0] bus_data_i,
  input  logic         bus_rd_i,
  input  logic         bus_fetch_i,
  input  logic         dbg_en_i,
  input  logic         dbg_active_i,
  output logic         bkpt_req_o
);
  localparam int unsigned NCH = 2;

  ctrl_t        ctrl_q;
  logic [W-1:0] addr_ref, data_ref;
  logic [W-1:0] ch_ref  [NCH];
  logic [W-1:0] ch_opnd [NCH];
  logic [NCH-1:0] ch_ign, ch_only, ch_rwe, ch_rw, ch_hit, ch_en;

  bkpt_regs #(.W(W), .LO_W(LO_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_hi_i    (wr_hi_i),
    .wr_lo_i    (wr_lo_i),
    .wr_data_i  (wr_data_i),
    .ctrl_o     (ctrl_q),
    .addr_ref_o (addr_ref),
    .data_ref_o (data_ref)
  );

  // channel 0: primary address; channel 1: data or second address
  always_comb begin
    ch_ref[0]  = addr_ref;
    ch_opnd[0] = bus_addr_i;
    ch_ign[0]  = ctrl_q.addr_ign_lo;
    ch_only[0] = 1'b0;
    ch_rwe[0]  = ctrl_q.rwe0;
    ch_rw[0]   = ctrl_q.rw0;
    ch_en[0]   = ctrl_q.en_a;
    ch_ref[1]  = data_ref;
    ch_opnd[1] = ctrl_q.dual ? bus_addr_i : bus_data_i;
    ch_ign[1]  = ctrl_q.data_ign_lo;
    ch_only[1] = ctrl_q.size8 && !ctrl_q.dual;
    ch_rwe[1]  = ctrl_q.rwe1;
    ch_rw[1]   = ctrl_q.rw1;
    ch_en[1]   = ctrl_q.en_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bkpt_cmp #(.W(W), .LO_W(LO_W)) u_cmp (
      .ref_i     (ch_ref[c]),
      .opnd_i    (ch_opnd[c]),
      .ign_lo_i  (ch_ign[c]),
      .only_lo_i (ch_only[c]),
      .rwe_i     (ch_rwe[c]),
      .rw_i      (ch_rw[c]),
      .bus_rd_i  (bus_rd_i),
      .hit_o     (ch_hit[c])
    );
  end

  bkpt_req u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (ch_hit),
    .en_i         (ch_en),
    .dual_i       (ctrl_q.dual),
    .prog_only_i  (ctrl_q.prog_only),
    .bus_valid_i  (bus_valid_i),
    .bus_fetch_i  (bus_fetch_i),
    .dbg_en_i     (dbg_en_i),
    .dbg_active_i (dbg_active_i),
    .req_o        (bkpt_req_o)
  );
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk
  import bkpt_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  bus_valid_i,
  input logic  bus_rd_i,
  input logic  bus_fetch_i,
  input logic  dbg_en_i,
  input logic  dbg_active_i,
  input logic  bkpt_req_o,
  input ctrl_t ctrl_i
);
  p_req_after_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_req_o |-> $past(bus_valid_i));

  p_no_req_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_req_o |-> $past(!dbg_active_i));

  p_req_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_req_o |-> $past(dbg_en_i));

  p_prog_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_req_o |-> $past(!ctrl_i.prog_only || bus_fetch_i));

  p_some_enable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_req_o |-> $past(ctrl_i.en_a || ctrl_i.en_d));

  p_dir_primary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_req_o |-> $past(ctrl_i.dual || !ctrl_i.en_a || !ctrl_i.rwe0 ||
                         (ctrl_i.rw0 == bus_rd_i)));

  p_dir_second_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_req_o |-> $past(ctrl_i.dual || !ctrl_i.en_d || !ctrl_i.rwe1 ||
                         (ctrl_i.rw1 == bus_rd_i)));
endmodule

bind bkpt_unit bkpt_unit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_valid_i  (bus_valid_i),
  .bus_rd_i     (bus_rd_i),
  .bus_fetch_i  (bus_fetch_i),
  .dbg_en_i     (dbg_en_i),
  .dbg_active_i (dbg_active_i),
  .bkpt_req_o   (bkpt_req_o),
  .ctrl_i       (ctrl_q)
);

// File: tb/bkpt_unit_tb.sv
module bkpt_unit_tb_top;
  localparam int unsigned W = 16;
  localparam logic [15:0] EN_A = 16'h0001, EN_D = 16'h0002, DUAL = 16'h0004,
                          PROG = 16'h0008, AIGN = 16'h0010, SZ8  = 16'h0020,
                          DIGN = 16'h0040, RWE0 = 16'h0080, RW0  = 16'h0100,
                          RWE1 = 16'h0200, RW1  = 16'h0400;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, wr_hi_i = 0, wr_lo_i = 0;
  logic [1:0] wr_addr_i = '0;
  logic [W-1:0] wr_data_i = '0, bus_addr_i = '0, bus_data_i = '0;
  logic bus_valid_i = 0, bus_rd_i = 0, bus_fetch_i = 0;
  logic dbg_en_i = 1, dbg_active_i = 0;
  logic bkpt_req_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  bkpt_unit #(.W(W)) dut_i (.*);

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: req=%0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d,
                    input logic hi = 1, input logic lo = 1);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d; wr_hi_i = hi; wr_lo_i = lo;
    @(negedge clk_i);
    wr_en_i = 0; wr_hi_i = 0; wr_lo_i = 0;
  endtask

  // one valid bus cycle; request sampled at the following negedge
  task automatic bus(input logic [15:0] a, input logic [15:0] d, input logic rd,
                     input logic fe, input logic exp, input string tag);
    @(negedge clk_i);
    bus_valid_i = 1; bus_addr_i = a; bus_data_i = d; bus_rd_i = rd; bus_fetch_i = fe;
    @(negedge clk_i);
    bus_valid_i = 0;
    chk(bkpt_req_o, exp, tag);
  endtask

  task automatic t_reset;
    chk(bkpt_req_o, 0, "R1 reset level");
    bus(16'h0000, 16'h0000, 1, 1, 0, "R1 zero regs disabled");
  endtask

  task automatic t_write;
    wr(1, 16'h1234); wr(0, EN_A);
    bus(16'h1234, 0, 1, 1, 1, "R2 full write");
    wr(1, 16'h9900, 1, 0);
    bus(16'h9934, 0, 1, 1, 1, "R2 high strobe only");
    wr(3, 16'h0000);
    bus(16'h9934, 0, 1, 1, 1, "R2 addr 3 ignored");
    wr(1, 16'h0077, 0, 1);
    bus(16'h9977, 0, 1, 1, 1, "R2 low strobe only");
  endtask

  task automatic t_combined;
    wr(1, 16'h1234); wr(2, 16'hABCD); wr(0, EN_A | EN_D);
    bus(16'h1234, 16'hABCD, 1, 1, 1, "R3 both match");
    bus(16'h1234, 16'hABCE, 1, 1, 0, "R3 data miss");
    bus(16'h1235, 16'hABCD, 1, 1, 0, "R3 addr miss");
    wr(0, EN_A);
    bus(16'h1234, 16'h0000, 1, 1, 1, "R3 addr only");
    wr(0, EN_D);
    bus(16'h0000, 16'hABCD, 1, 1, 1, "R3 data only");
    bus(16'hABCD, 16'h1234, 1, 1, 0, "R3 data reg not on addr");
  endtask

  task automatic t_dual;
    wr(1, 16'h1234); wr(2, 16'h5678); wr(0, DUAL | EN_A | EN_D);
    bus(16'h5678, 16'h0000, 1, 1, 1, "R4 second addr bp");
    bus(16'h1234, 16'h0000, 1, 1, 1, "R4 first addr bp");
    bus(16'h0000, 16'h5678, 1, 1, 0, "R4 data bus unused");
    wr(0, DUAL | EN_A);
    bus(16'h5678, 16'h0000, 1, 1, 0, "R4 second disabled");
    bus(16'h1234, 16'h0000, 1, 1, 1, "R4 first alone");
  endtask

  task automatic t_size;
    wr(2, 16'hABCD); wr(0, EN_D | SZ8);
    bus(16'h0000, 16'h12CD, 1, 1, 1, "R5 low byte match");
    bus(16'h0000, 16'hAB00, 1, 1, 0, "R5 low byte miss");
    wr(0, DUAL | EN_D | SZ8);
    bus(16'h12CD, 16'h0000, 1, 1, 0, "R5 size ignored dual");
    bus(16'hABCD, 16'h0000, 1, 1, 1, "R5 full addr dual");
  endtask

  task automatic t_lowbyte;
    wr(1, 16'h1234); wr(0, EN_A | AIGN);
    bus(16'h12FF, 16'h0000, 1, 1, 1, "R6 low byte ignored");
    bus(16'h1334, 16'h0000, 1, 1, 0, "R6 high byte checked");
    wr(2, 16'h5678); wr(0, DUAL | EN_D | DIGN);
    bus(16'h5600, 16'h0000, 1, 1, 1, "R6 second ignore");
    bus(16'h5778, 16'h0000, 1, 1, 0, "R6 second high byte");
  endtask

  task automatic t_prog;
    wr(1, 16'h1234); wr(0, EN_A | PROG);
    bus(16'h1234, 0, 1, 0, 0, "R7 data cycle blocked");
    bus(16'h1234, 0, 1, 1, 1, "R7 fetch fires");
    wr(0, EN_A);
    bus(16'h1234, 0, 1, 0, 1, "R7 off data fires");
  endtask

  task automatic t_rw;
    wr(1, 16'h1234); wr(0, EN_A | RWE0 | RW0);
    bus(16'h1234, 0, 1, 0, 1, "R8 read qualified");
    bus(16'h1234, 0, 0, 0, 0, "R8 write rejected");
    wr(0, EN_A | RWE0);
    bus(16'h1234, 0, 0, 0, 1, "R8 write qualified");
    wr(2, 16'h5678); wr(0, DUAL | EN_D | RWE1);
    bus(16'h5678, 0, 1, 0, 0, "R8 dual read rejected");
    bus(16'h5678, 0, 0, 0, 1, "R8 dual write");
    wr(0, DUAL | EN_A | EN_D | RWE1);
    bus(16'h1234, 0, 1, 0, 1, "R8 other bp unqualified");
  endtask

  task automatic t_gate;
    wr(1, 16'h1234); wr(0, EN_A);
    dbg_en_i = 0;
    bus(16'h1234, 0, 1, 1, 0, "R10 debug disabled");
    dbg_en_i = 1; dbg_active_i = 1;
    bus(16'h1234, 0, 1, 1, 0, "R9 debug active");
    dbg_active_i = 0;
    bus(16'h1234, 0, 1, 1, 1, "R9 R10 normal");
  endtask

  task automatic t_timing;
    wr(1, 16'h1234); wr(0, EN_A);
    @(negedge clk_i);
    bus_valid_i = 1; bus_addr_i = 16'h1234;
    @(negedge clk_i);
    bus_addr_i = 16'h0001;
    chk(bkpt_req_o, 1, "R11 pulse after cycle");
    @(negedge clk_i);
    bus_valid_i = 0; bus_addr_i = 16'h1234;
    chk(bkpt_req_o, 0, "R11 single cycle");
    @(negedge clk_i);
    chk(bkpt_req_o, 0, "R11 idle bus match");
    bus_valid_i = 1;
    @(negedge clk_i);
    chk(bkpt_req_o, 1, "R11 back to back a");
    @(negedge clk_i);
    bus_valid_i = 0;
    chk(bkpt_req_o, 1, "R11 back to back b");
    @(negedge clk_i);
    chk(bkpt_req_o, 0, "R11 falls");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset;
    t_write;
    t_combined;
    t_dual;
    t_size;
    t_lowbyte;
    t_prog;
    t_rw;
    t_gate;
    t_timing;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule